// File: doc/BRIEF.md
# Interconnect Performance Counter Bank

This block counts activity inside a bus interconnect. It holds five 32-bit counters. Counter index 0 is a cycle counter that advances on every clock while it is enabled. Counters 1 to 4 are event counters. Each event counter watches one line of a bank of single-cycle event pulses, organised as 8 source ports with 32 codes each. An 8-bit selector picks the line: bits 7:5 give the port (0–4 are slave-side ports, 5–7 are master-side ports) and bits 4:0 give the code within that port.

Software reaches the block through a simple single-cycle register bus. A write takes effect at the clock edge on which `bus_wen` is sampled high. Read data is combinational from `bus_addr`. Each counter has its own 4 KiB register page, at index × 0x1000. A shared control register holds a global enable bit and reports how many event counters exist. An identification register reports the revision. When a counter wraps it sets a sticky overflow flag, and that flag drives a dedicated interrupt line. Software clears the flag by writing 1 to it. The five interrupt lines may be ORed outside the block into one shared line.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, all counts, per-counter enables, selectors, overflow flags and `irq_ovf` are 0. The control register (0x0100) reads 0x00002000: bits 15:11 hold the event counter count 4, and bit 0 (global enable) is 0. The identification register (0x0FE8) reads the revision in bits 7:4, which is 0x00000010 for the default revision 1.
- R2: Counter i has its page at i × 0x1000. Within the page, +0x000 is the selector (8 bits, reads back), +0x004 is the count, +0x008 is the counter enable (bit 0) and +0x00C is the overflow flag (bit 0). Control bit 0 at 0x0100 is the global enable.
- R3: Counter 0 adds one on every clock edge at which both enables are 1, whatever its selector holds.
- R4: Counter i (1..4) adds one on every clock edge at which both enables are 1 and event line port×32+code is high, where port is selector bits 7:5 and code is selector bits 4:0.
- R5: A selector whose code is 21 or higher (parameter `EVT_CODES`) counts nothing, even when its line is high.
- R6: No counter moves while the global enable is 0 or its own enable is 0.
- R7: Software can write the count register to preload it. A count write wins over an event in the same cycle.
- R8: A count that steps from 0xFFFFFFFF wraps to 0 and sets that counter's overflow flag. `irq_ovf[i]` is high while flag i is set.
- R9: Writing 1 to overflow bit 0 clears the flag, and writing 0 leaves it unchanged. If a wrap and a clear fall in the same cycle, the flag stays set.
- R10: Reads from unmapped addresses (other offsets, pages 5 and above) return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| evt_lines | input | 256 | Event pulses, bit port×32+code |
| irq_ovf | output | 5 | Per-counter overflow interrupt |

## Verification
A register write, a preload or an event pulse present during cycle k changes state at the edge that ends cycle k. Read data follows the address within the same cycle, so a result is due one edge after its stimulus. The bench drives inputs at the falling edge and reads back after the next falling edge, so exactly one rising edge separates stimulus and check. Enabling and then disabling the cycle counter spans the two write edges: the counter also counts at the edge that disables it, and the expected value counts that edge as well.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 32;
  localparam int SEL_W      = 8;
  localparam int PAGE_LSB   = 12;

  localparam logic [11:0] OFS_SEL  = 12'h000;
  localparam logic [11:0] OFS_CNT  = 12'h004;
  localparam logic [11:0] OFS_EN   = 12'h008;
  localparam logic [11:0] OFS_OVF  = 12'h00C;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 16'h0100;
  localparam logic [ADDR_W-1:0] ADR_IDENT = 16'h0FE8;

  typedef struct packed {
    logic sel_we;
    logic cnt_we;
    logic en_we;
    logic ovf_we;
  } cnt_wr_t;

  // Next count value and the wrap indication for one step.
  function automatic logic [DATA_W:0] count_step(input logic [DATA_W-1:0] cur,
                                                 input logic inc);
    logic [DATA_W:0] sum;
    sum = {1'b0, cur} + {{DATA_W{1'b0}}, inc};
    return sum;
  endfunction

  // Control register image: counter count in 15:11, global enable in bit 0.
  function automatic logic [DATA_W-1:0] ctrl_image(input logic [4:0] n_evt,
                                                   input logic gen_en);
    return {16'h0000, n_evt, 10'b0, gen_en};
  endfunction

  function automatic logic [DATA_W-1:0] ident_image(input logic [3:0] rev);
    return {24'h000000, rev, 4'h0};
  endfunction

endpackage

// File: rtl/pcb_evt_sel.sv
module pcb_evt_sel
  import pcb_pkg::*;
#(
  parameter int PORTS     = 8,
  parameter int CODES     = 32,
  parameter int EVT_CODES = 21
) (
  input  logic [PORTS*CODES-1:0] evt_lines,
  input  logic [SEL_W-1:0]       sel,
  output logic                   hit
);
  localparam int LINES  = PORTS * CODES;
  localparam int IDX_W  = $clog2(LINES);
  localparam int CODE_W = $clog2(CODES);

  logic [SEL_W-CODE_W-1:0] sel_port;
  logic [CODE_W-1:0]       sel_code;
  logic [IDX_W-1:0]        line_idx;
  logic                    code_ok;

  assign sel_port = sel[SEL_W-1:CODE_W];
  assign sel_code = sel[CODE_W-1:0];
  assign code_ok  = (int'(sel_code) < EVT_CODES);

  always_comb begin
    line_idx = IDX_W'(sel_port) * IDX_W'(CODES) + IDX_W'(sel_code);
    hit      = code_ok && evt_lines[line_idx];
  end

endmodule

// File: rtl/pcb_counter.sv
module pcb_counter
  import pcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_en,
  input  logic              evt_hit,
  input  cnt_wr_t           wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEL_W-1:0]  sel_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic              en_q,
  output logic              ovf_q
);
  logic              inc;
  logic [DATA_W:0]   step;
  logic              wrap;
  logic              ovf_clr;

  assign inc     = gen_en & en_q & evt_hit;
  assign step    = count_step(cnt_q, inc);
  assign wrap    = step[DATA_W] & ~wr.cnt_we;
  assign ovf_clr = wr.ovf_we & wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (wr.sel_we) sel_q <= wdata[SEL_W-1:0];
      if (wr.en_we)  en_q  <= wdata[0];
      if (wr.cnt_we) cnt_q <= wdata;
      else           cnt_q <= step[DATA_W-1:0];
      if (wrap)         ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  // R7
  preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr.cnt_we |=> cnt_q == $past(wdata));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr.cnt_we) |=> cnt_q == $past(cnt_q) + 32'd1);

  // R6
  gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !wr.cnt_we) |=> $stable(cnt_q));

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (ovf_q && cnt_q == '0));

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !wrap) |=> !ovf_q);

  // R9
  w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

endmodule

// File: rtl/pcb_regdec.sv
module pcb_regdec
  import pcb_pkg::*;
#(
  parameter int N_CNT = 5
) (
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] ctrl_rd,
  input  logic [DATA_W-1:0] ident_rd,
  input  logic [SEL_W-1:0]  sel_rd [N_CNT],
  input  logic [DATA_W-1:0] cnt_rd [N_CNT],
  input  logic              en_rd  [N_CNT],
  input  logic              ovf_rd [N_CNT],
  output cnt_wr_t           cnt_wr [N_CNT],
  output logic              ctrl_we,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [ADDR_W-PAGE_LSB-1:0] page;
  logic [PAGE_LSB-1:0]        ofs;

  assign page    = bus_addr[ADDR_W-1:PAGE_LSB];
  assign ofs     = bus_addr[PAGE_LSB-1:0];
  assign ctrl_we = bus_wen && (bus_addr == ADR_CTRL);

  for (genvar i = 0; i < N_CNT; i++) begin : g_wr
    logic hit_page;
    assign hit_page         = bus_wen && (int'(page) == i);
    assign cnt_wr[i].sel_we = hit_page && (ofs == OFS_SEL);
    assign cnt_wr[i].cnt_we = hit_page && (ofs == OFS_CNT);
    assign cnt_wr[i].en_we  = hit_page && (ofs == OFS_EN);
    assign cnt_wr[i].ovf_we = hit_page && (ofs == OFS_OVF);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADR_CTRL) begin
      bus_rdata = ctrl_rd;
    end else if (bus_addr == ADR_IDENT) begin
      bus_rdata = ident_rd;
    end else begin
      for (int i = 0; i < N_CNT; i++) begin
        if (int'(page) == i) begin
          unique case (ofs)
            OFS_SEL: bus_rdata = {{(DATA_W-SEL_W){1'b0}}, sel_rd[i]};
            OFS_CNT: bus_rdata = cnt_rd[i];
            OFS_EN:  bus_rdata = {{(DATA_W-1){1'b0}}, en_rd[i]};
            OFS_OVF: bus_rdata = {{(DATA_W-1){1'b0}}, ovf_rd[i]};
            default: bus_rdata = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int NUM_EVT_CNT = 4,
  parameter int PORTS       = 8,
  parameter int CODES       = 32,
  parameter int EVT_CODES   = 21,
  parameter logic [3:0] REVISION = 4'h1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wen,
  input  logic [15:0]              bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [PORTS*CODES-1:0]   evt_lines,
  output logic [NUM_EVT_CNT:0]     irq_ovf
);
  localparam int N_CNT = NUM_EVT_CNT + 1;

  logic              gen_en;
  logic              ctrl_we;
  cnt_wr_t           cnt_wr [N_CNT];
  logic [SEL_W-1:0]  sel_q  [N_CNT];
  logic [DATA_W-1:0] cnt_q  [N_CNT];
  logic              en_q   [N_CNT];
  logic              ovf_q  [N_CNT];
  logic              hit    [N_CNT];

  always_ff @(posedge clk) begin
    if (!rst_n)       gen_en <= 1'b0;
    else if (ctrl_we) gen_en <= bus_wdata[0];
  end

  pcb_regdec #(.N_CNT(N_CNT)) u_regdec (
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .ctrl_rd   (ctrl_image(5'(NUM_EVT_CNT), gen_en)),
    .ident_rd  (ident_image(REVISION)),
    .sel_rd    (sel_q),
    .cnt_rd    (cnt_q),
    .en_rd     (en_q),
    .ovf_rd    (ovf_q),
    .cnt_wr    (cnt_wr),
    .ctrl_we   (ctrl_we),
    .bus_rdata (bus_rdata)
  );

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    if (i == 0) begin : g_cycle
      assign hit[i] = 1'b1;
    end else begin : g_event
      pcb_evt_sel #(.PORTS(PORTS), .CODES(CODES), .EVT_CODES(EVT_CODES)) u_sel (
        .evt_lines (evt_lines),
        .sel       (sel_q[i]),
        .hit       (hit[i])
      );
    end

    pcb_counter u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .gen_en  (gen_en),
      .evt_hit (hit[i]),
      .wr      (cnt_wr[i]),
      .wdata   (bus_wdata),
      .sel_q   (sel_q[i]),
      .cnt_q   (cnt_q[i]),
      .en_q    (en_q[i]),
      .ovf_q   (ovf_q[i])
    );

    assign irq_ovf[i] = ovf_q[i];
  end

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ovf[0]) |-> $past(gen_en));

  // R3
  cycle_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && en_q[0] && !cnt_wr[0].cnt_we) |=> cnt_q[0] != $past(cnt_q[0]));

endmodule

// File: tb/test_perf_counter_bank.sv
module test_perf_counter_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [255:0] evt_lines = '0;
  logic [4:0]  irq_ovf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_counter_bank i_perf_counter_bank (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_lines(evt_lines),
    .irq_ovf(irq_ovf)
  );

  typedef struct packed {
    logic [2:0] idx;
    logic [7:0] sel;
    logic [7:0] line;
    logic [3:0] pulses;
    logic [7:0] expect_cnt;
  } vec_t;

  // Expected counts: pulses when line == port*32+code and code < 21, else 0.
  localparam vec_t VECS [8] = '{
    '{3'd1, 8'h00, 8'd0,   4'd3, 8'd3},   // R4 port 0 code 0
    '{3'd2, 8'h25, 8'd37,  4'd4, 8'd4},   // R4 port 1 code 5
    '{3'd3, 8'hE7, 8'd231, 4'd2, 8'd2},   // R4 port 7 code 7
    '{3'd4, 8'hA2, 8'd162, 4'd5, 8'd5},   // R4 port 5 code 2
    '{3'd1, 8'h25, 8'd38,  4'd3, 8'd0},   // R4 other line ignored
    '{3'd2, 8'h14, 8'd20,  4'd2, 8'd2},   // R5 last implemented code
    '{3'd3, 8'h15, 8'd21,  4'd3, 8'd0},   // R5 code 21 counts nothing
    '{3'd4, 8'hE7, 8'd231, 4'd1, 8'd1}    // R4 single pulse
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input int line, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt_lines[line] = 1'b1;
      @(negedge clk); evt_lines[line] = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(16'h0100, v); chk("R1 ctrl", v, 32'h0000_2000);
    rd(16'h0FE8, v); chk("R1 ident", v, 32'h0000_0010);
    for (int i = 0; i < 5; i++) begin
      rd(16'(i*4096 + 4), v); chk("R1 count", v, 32'h0);
      rd(16'(i*4096),     v); chk("R1 sel",   v, 32'h0);
      rd(16'(i*4096 + 8), v); chk("R1 en",    v, 32'h0);
      rd(16'(i*4096 + 12), v); chk("R1 ovf",  v, 32'h0);
    end
    chk("R1 irq", {27'b0, irq_ovf}, 32'h0);

    // R2 enable on, selector readback
    wr(16'h0100, 32'h1);
    rd(16'h0100, v); chk("R2 ctrl enable", v, 32'h0000_2001);
    wr(16'h2000, 32'hFFFF_FF5A);
    rd(16'h2000, v); chk("R2 sel 8 bits", v, 32'h0000_005A);

    // R4 R5 table
    for (int t = 0; t < 8; t++) begin
      logic [15:0] pg;
      pg = 16'(VECS[t].idx) << 12;
      wr(pg,        32'(VECS[t].sel));
      wr(pg + 16'h4, 32'h0);
      wr(pg + 16'h8, 32'h1);
      pulse(int'(VECS[t].line), int'(VECS[t].pulses));
      wr(pg + 16'h8, 32'h0);
      rd(pg + 16'h4, v);
      chk("R4/R5 table", v, 32'(VECS[t].expect_cnt));
    end

    // R3 cycle counter ignores selector; counts edges from enable to disable inclusive
    wr(16'h0000, 32'hFF);
    wr(16'h0004, 32'h0);
    wr(16'h0008, 32'h1);
    repeat (10) @(posedge clk);
    wr(16'h0008, 32'h0);
    rd(16'h0004, v); chk("R3 cycle count", v, 32'd11);

    // R6 own enable off
    wr(16'h2000, 32'h25); wr(16'h2004, 32'h0); wr(16'h2008, 32'h0);
    pulse(37, 3);
    rd(16'h2004, v); chk("R6 own enable off", v, 32'h0);
    // R6 global enable off
    wr(16'h2008, 32'h1); wr(16'h0100, 32'h0);
    pulse(37, 3);
    rd(16'h2004, v); chk("R6 global enable off", v, 32'h0);
    wr(16'h0100, 32'h1);

    // R7 preload wins over simultaneous event
    wr(16'h3000, 32'hE7); wr(16'h3008, 32'h1);
    @(negedge clk);
    evt_lines[231] = 1'b1; bus_wen = 1'b1; bus_addr = 16'h3004; bus_wdata = 32'h100;
    @(posedge clk); #1;
    bus_wen = 1'b0; evt_lines[231] = 1'b0;
    rd(16'h3004, v); chk("R7 write priority", v, 32'h100);
    pulse(231, 1);
    rd(16'h3004, v); chk("R7 count after preload", v, 32'h101);

    // R8 wrap
    wr(16'h1000, 32'h43); wr(16'h1004, 32'hFFFF_FFFE); wr(16'h1008, 32'h1);
    pulse(67, 1);
    rd(16'h100C, v); chk("R8 no flag before wrap", v, 32'h0);
    pulse(67, 1);
    rd(16'h1004, v); chk("R8 wrapped to zero", v, 32'h0);
    rd(16'h100C, v); chk("R8 flag set", v, 32'h1);
    chk("R8 irq line", {27'b0, irq_ovf}, 32'h0000_0002);

    // R9 write 0 keeps, write 1 clears
    wr(16'h100C, 32'h0);
    rd(16'h100C, v); chk("R9 write 0 no effect", v, 32'h1);
    wr(16'h100C, 32'h1);
    rd(16'h100C, v); chk("R9 write 1 clears", v, 32'h0);
    chk("R9 irq low", {27'b0, irq_ovf}, 32'h0);

    // R9 wrap and clear together: flag stays set
    wr(16'h1004, 32'hFFFF_FFFF);
    @(negedge clk);
    evt_lines[67] = 1'b1; bus_wen = 1'b1; bus_addr = 16'h100C; bus_wdata = 32'h1;
    @(posedge clk); #1;
    bus_wen = 1'b0; evt_lines[67] = 1'b0;
    rd(16'h100C, v); chk("R9 set wins over clear", v, 32'h1);
    wr(16'h100C, 32'h1);

    // R10 unmapped
    rd(16'h0010, v); chk("R10 unmapped offset", v, 32'h0);
    wr(16'h5004, 32'hDEAD_BEEF);
    rd(16'h5004, v); chk("R10 page 5", v, 32'h0);
    wr(16'h1010, 32'h55);
    rd(16'h1000, v); chk("R10 write ignored", v, 32'h43);
    rd(16'h1010, v); chk("R10 unmapped read", v, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule